// File: doc/BRIEF.md
# Row-First Address-Event Readout Controller

This block drains firing pixels of an image array as a stream of address events. Each pixel holds one request bit in a flattened bitmap. When the controller is idle and any row has a firing pixel, a row arbiter picks one row. The controller then emits that row's address as a header. A column arbiter then walks through the firing pixels of that row and emits one column address per pixel. Every column address that the consumer accepts causes a one-cycle acknowledge to that pixel, and the pixel is expected to drop its request and reset.

Rows wait behind the active row for as long as it has pending pixels, so a busy row delays every other waiting row. Both arbiters share one mode input. In fixed mode the lowest index always wins. In fair mode priority starts one place after the last index granted, wrapping around. A ready input from the consumer stalls emission without dropping any event. After the last pending column is served, the controller spends one cycle rechecking the row before it releases it.

Top module: `aer_row_col_readout`

## Requirements
- R1: When idle and any pixel requests, the controller emits a header the following cycle: row_vld_o high and addr_o holding the selected row number. It holds the header until out_ready_i is high.
- R2: After the header is accepted, each pending pixel of that row is emitted once as a column address with col_vld_o high, one per accepted cycle. No other row header appears until the row is released.
- R3: row_vld_o and col_vld_o are never high in the same cycle.
- R4: In the cycle after a column address is accepted, ack_o has exactly one bit high, at index row*COLS+col, for one cycle only. At all other times ack_o is zero.
- R5: With fair_mode_i low, the lowest-numbered pending row, and within a row the lowest-numbered pending column, is chosen.
- R6: With fair_mode_i high, the search starts at one past the last granted index, wrapping to 0. Each arbiter keeps its own pointer, and the pointer persists across rows and across mode changes.
- R7: While out_ready_i is low, the current strobe stays high and the header address stays stable. Every fired pixel is still emitted exactly once.
- R8: A pixel that fires in the active row while that row is being served joins the current service. A pixel in another row waits for a later row arbitration.
- R9: When the active row has no pending column, the controller enters one recheck cycle with no strobe. It then resumes column service if a new pixel is pending in that row; otherwise it returns to idle.
- R10: During reset and right after it, both strobes and ack_o are low and both priority pointers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fair_mode_i | input | 1 | 0: fixed priority; 1: rotating priority for both arbiters |
| req_i | input | ROWS*COLS | Pixel request bitmap; bit row*COLS+col |
| out_ready_i | input | 1 | Consumer accepts the current strobe when high |
| addr_o | output | max(log2 ROWS, log2 COLS) | Row or column address, zero-extended |
| row_vld_o | output | 1 | addr_o carries a row header |
| col_vld_o | output | 1 | addr_o carries a column address |
| ack_o | output | ROWS*COLS | One-cycle per-pixel acknowledge/reset |

## Verification
The bench builds the block with 4 rows and 6 columns. Six is not a power of two, so the column pointer must wrap from 5 to 0 rather than overflow naturally. Four rows keep drain sequences short enough to run full-array bursts in both modes with a pseudo-random ready pattern. The narrow address width also means the row and column addresses share a 3-bit bus, with the row value zero-extended.

// File: rtl/aer_readout_pkg.sv
package aer_readout_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HEAD  = 2'd1,
    ST_COLS  = 2'd2,
    ST_RECHK = 2'd3
  } rd_state_e;
endpackage

// File: rtl/aer_rst_sync.sv
module aer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/aer_prio_arb.sv
module aer_prio_arb #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fair_i,
  input  logic [N-1:0]  req_i,
  input  logic          adv_i,
  output logic          any_o,
  output logic [IW-1:0] gnt_o
);
  logic [IW-1:0] ptr_q, ptr_d, base;

  // search from base upward, wrapping at N
  always_comb begin
    base  = fair_i ? ptr_q : '0;
    gnt_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = int'(base) + i;
      if (idx >= N) idx = idx - N;
      if (!any_o && req_i[idx]) begin
        any_o = 1'b1;
        gnt_o = IW'(idx);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv_i) ptr_d = (gnt_o == IW'(N-1)) ? '0 : gnt_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R5/R6: a grant always points at a live request
  a_r5_grant_live: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> req_i[gnt_o]);
  // R6: the rotation pointer stays inside the array
  a_r6_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < N);
  // R6: after an advance the pointer sits one past the old grant
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && any_o) |=> (int'(ptr_q) == ((int'($past(gnt_o)) + 1) % N)));
endmodule

// File: rtl/aer_row_col_readout.sv
module aer_row_col_readout
  import aer_readout_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 16,
  localparam int NPIX = ROWS * COLS,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int AW = (RW > CW) ? RW : CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fair_mode_i,
  input  logic [NPIX-1:0] req_i,
  input  logic            out_ready_i,
  output logic [AW-1:0]   addr_o,
  output logic            row_vld_o,
  output logic            col_vld_o,
  output logic [NPIX-1:0] ack_o
);
  logic            rst_sync_n;
  rd_state_e       state_q, state_d;
  logic [RW-1:0]   act_row_q;
  logic [COLS-1:0] served_q, served_d;
  logic [NPIX-1:0] ack_q, ack_d;
  logic [COLS-1:0] row_req [ROWS];
  logic [ROWS-1:0] row_pend;
  logic [COLS-1:0] col_pend;
  logic            row_any, col_any, row_ld, col_acc;
  logic [RW-1:0]   row_gnt;
  logic [CW-1:0]   col_gnt;

  aer_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_req[r]  = req_i[r*COLS +: COLS];
    assign row_pend[r] = |row_req[r];
  end

  assign col_pend = row_req[act_row_q] & ~served_q;

  aer_prio_arb #(.N(ROWS)) u_row_arb (
    .clk(clk), .rst_n(rst_sync_n), .fair_i(fair_mode_i),
    .req_i(row_pend), .adv_i(row_ld), .any_o(row_any), .gnt_o(row_gnt)
  );

  aer_prio_arb #(.N(COLS)) u_col_arb (
    .clk(clk), .rst_n(rst_sync_n), .fair_i(fair_mode_i),
    .req_i(col_pend), .adv_i(col_acc), .any_o(col_any), .gnt_o(col_gnt)
  );

  // next-state and output decode
  always_comb begin
    state_d   = state_q;
    served_d  = served_q;
    ack_d     = '0;
    row_ld    = 1'b0;
    col_acc   = 1'b0;
    row_vld_o = 1'b0;
    col_vld_o = 1'b0;
    addr_o    = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (row_any) begin
          row_ld  = 1'b1;
          state_d = ST_HEAD;
        end
      end
      ST_HEAD: begin
        row_vld_o = 1'b1;
        addr_o    = AW'(act_row_q);
        if (out_ready_i) state_d = ST_COLS;
      end
      ST_COLS: begin
        if (col_any) begin
          col_vld_o = 1'b1;
          addr_o    = AW'(col_gnt);
          if (out_ready_i) begin
            col_acc           = 1'b1;
            served_d[col_gnt] = 1'b1;
            for (int r = 0; r < ROWS; r++)
              for (int c = 0; c < COLS; c++)
                if (act_row_q == RW'(r) && col_gnt == CW'(c))
                  ack_d[r*COLS + c] = 1'b1;
          end
        end else begin
          state_d = ST_RECHK;
        end
      end
      ST_RECHK: begin
        if (col_any) begin
          state_d = ST_COLS;
        end else begin
          served_d = '0;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= ST_IDLE;
      act_row_q <= '0;
      served_q  <= '0;
      ack_q     <= '0;
    end else begin
      state_q  <= state_d;
      served_q <= served_d;
      ack_q    <= ack_d;
      if (row_ld) act_row_q <= row_gnt;
    end
  end

  assign ack_o = ack_q;

  // R3: one strobe at a time
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(row_vld_o && col_vld_o));
  // R7: a stalled header keeps its strobe and address
  a_r7_head_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (row_vld_o && !out_ready_i) |=> (row_vld_o && $stable(addr_o)));
  // R7: a stalled column strobe is not withdrawn
  a_r7_col_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (col_vld_o && !out_ready_i) |=> col_vld_o);
  // R4: an accepted column yields exactly one acknowledge next cycle
  a_r4_ack_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (col_vld_o && out_ready_i) |=> ($countones(ack_o) == 1));
  // R4: no acknowledge without a preceding accepted column
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(col_vld_o && out_ready_i) |=> (ack_o == '0));
  // R9: an empty recheck releases the row
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_RECHK && !col_any) |=> (state_q == ST_IDLE && served_q == '0));
  // R2: the header is followed by column service, never another header
  a_r2_head_to_cols: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (row_vld_o && out_ready_i) |=> !row_vld_o);
endmodule

// File: tb/aer_row_col_readout_test.sv
module aer_row_col_readout_test;
  localparam int ROWS = 4;
  localparam int COLS = 6;
  localparam int N    = ROWS * COLS;
  localparam int AW   = 3;

  logic          clk, rst_n, fair, rdy;
  logic [N-1:0]  reqv, inj;
  logic [AW-1:0] addr;
  logic          rv, cv;
  logic [N-1:0]  ack;

  aer_row_col_readout #(.ROWS(ROWS), .COLS(COLS)) uut (
    .clk(clk), .rst_n(rst_n), .fair_mode_i(fair), .req_i(reqv),
    .out_ready_i(rdy), .addr_o(addr), .row_vld_o(rv), .col_vld_o(cv),
    .ack_o(ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;
  int rmode = 0;
  logic [15:0] lf = 16'hACE1;
  int ms = 0, mrow = 0, mrptr = 0, mcptr = 0, mack = -1;
  logic [COLS-1:0] mserved = '0;
  int emitted = 0, fired = 0;
  bit modelon = 0;

  task automatic chk(input bit ok, input string tg, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tg, act, exp, $time);
    end
  endtask

  function automatic int pick_row();
    int base = fair ? mrptr : 0;
    for (int i = 0; i < ROWS; i++) begin
      int idx = (base + i) % ROWS;
      if (reqv[idx*COLS +: COLS] != '0) return idx;
    end
    return -1;
  endfunction

  function automatic int pick_col();
    int base = fair ? mcptr : 0;
    for (int i = 0; i < COLS; i++) begin
      int idx = (base + i) % COLS;
      if (reqv[mrow*COLS + idx] && !mserved[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic check_outputs();
    bit erv, ecv;
    int eaddr, c;
    logic [N-1:0] eack;
    string tg;
    erv = 0; ecv = 0; eaddr = 0; eack = '0;
    if (ms == 1) begin erv = 1; eaddr = mrow; end
    if (ms == 2) begin
      c = pick_col();
      if (c >= 0) begin ecv = 1; eaddr = c; end
    end
    if (mack >= 0) eack[mack] = 1'b1;
    if (ms == 3)                 tg = "R9";
    else if (!rdy && ms != 0)    tg = "R7";
    else if (ms == 1)            tg = "R1";
    else                         tg = "R2";
    chk(rv == erv, {tg, " row_vld"}, int'(rv), int'(erv));
    chk(cv == ecv, {tg, " col_vld"}, int'(cv), int'(ecv));
    chk(!(rv && cv), "R3 both strobes", int'({rv, cv}), 0);
    if (erv || ecv)
      chk(int'(addr) == eaddr, (ecv ? (fair ? "R6 col addr" : "R5 col addr") :
          (fair ? "R6 row addr" : "R5 row addr")), int'(addr), eaddr);
    chk(ack == eack, "R4 ack", int'(ack), int'(eack));
  endtask

  task automatic update_model();
    int nack, r, c;
    nack = -1;
    case (ms)
      0: begin
        r = pick_row();
        if (r >= 0) begin mrow = r; mrptr = (r + 1) % ROWS; ms = 1; end
      end
      1: if (rdy) ms = 2;
      2: begin
        c = pick_col();
        if (c >= 0) begin
          if (rdy) begin
            mserved[c] = 1'b1;
            nack = mrow*COLS + c;
            mcptr = (c + 1) % COLS;
            emitted++;
          end
        end else ms = 3;
      end
      default: begin
        if (pick_col() >= 0) ms = 2;
        else begin mserved = '0; ms = 0; end
      end
    endcase
    mack = nack;
  endtask

  task automatic step();
    @(negedge clk);
    reqv = reqv & ~ack;
    fired += $countones(inj & ~reqv);
    reqv = reqv | inj;
    inj = '0;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    rdy = (rmode == 0) ? 1'b1 : (lf[0] | lf[3]);
    #1;
    if (modelon) begin
      check_outputs();
      update_model();
    end
  endtask

  task automatic fire(input int r, input int c);
    inj[r*COLS + c] = 1'b1;
  endtask

  task automatic drain();
    int quiet = 0;
    for (int k = 0; k < 2000 && quiet < 3; k++) begin
      step();
      if (ms == 0 && reqv == '0) quiet++; else quiet = 0;
    end
  endtask

  task automatic phase_begin(input bit f, input int rm);
    fair = f; rmode = rm; emitted = 0; fired = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reqv = '0; inj = '0; rdy = 1'b1; fair = 1'b0;
    repeat (3) begin
      step();
      chk(!rv && !cv, "R10 strobes in reset", int'({rv, cv}), 0);
      chk(ack == '0, "R10 ack in reset", int'(ack), 0);
    end
    rst_n = 1'b1;
    repeat (3) step();
    chk(!rv && !cv && ack == '0, "R10 idle after reset", int'({rv, cv}), 0);
    modelon = 1;

    // fixed priority, two rows at once
    phase_begin(0, 0);
    fire(3, 1); fire(3, 4); fire(1, 0); fire(1, 2); fire(1, 5);
    drain();
    chk(emitted == fired, "R2 all columns emitted", emitted, fired);

    // fixed priority with stalls
    phase_begin(0, 1);
    for (int c = 0; c < COLS; c++) fire(0, c);
    fire(2, 3);
    drain();
    chk(emitted == fired, "R7 no event lost under stall", emitted, fired);

    // fair priority, two rounds to wrap the pointers
    phase_begin(1, 0);
    fire(0, 5); fire(0, 1); fire(2, 0); fire(2, 4); fire(3, 2);
    drain();
    fire(1, 3); fire(1, 0); fire(3, 5); fire(0, 0);
    drain();
    chk(emitted == fired, "R6 fair rounds complete", emitted, fired);

    // late arrivals during a row's service
    phase_begin(1, 0);
    fire(2, 1); fire(2, 3);
    for (int k = 0; k < 50 && ms != 2; k++) step();
    fire(2, 0); fire(2, 5); fire(0, 2);
    step();
    chk(ms == 2 && mrow == 2, "R8 row still active", mrow, 2);
    drain();
    chk(reqv == '0, "R8 every pixel cleared", int'(reqv), 0);
    chk(emitted == fired, "R8 late pixels emitted", emitted, fired);

    // whole array, fair, stalls
    phase_begin(1, 1);
    inj = '1;
    drain();
    chk(emitted == N, "R2 full array fair", emitted, N);

    // whole array, fixed, stalls
    phase_begin(0, 1);
    inj = '1;
    drain();
    chk(emitted == N, "R5 full array fixed", emitted, N);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule